// File: doc/BRIEF.md
# Single-Cycle Multiply-Accumulate Execute and Writeback Slice

This block is the execute and writeback part of a single-cycle 32-bit integer core. It adds a custom multiply-accumulate instruction to the core. It receives the current instruction word, the result of the base ALU and the data returned by a load. It decodes the instruction into a small set of control strobes. It then chooses one of three writeback sources and writes the chosen value into a 32-entry register file at the next rising clock edge.

The multiply-accumulate instruction computes rd = rd + rs1 × rs2 as a signed 32-bit operation in one clock. For this, the register file has a third combinational read port that is addressed by the destination field. The old accumulator is therefore read in the same cycle as the two multiplicands. All three read ports are visible as outputs, so the surrounding core, and a test harness, can observe register contents through the normal datapath.

Top module: `mac_wb_slice`

## Requirements
- R1: An instruction with opcode bits [6:0] = 7'b0001011, funct3 bits [14:12] = 3'b000 and funct7 bits [31:25] = 7'b0000001 drives macEnable = 1, regWrite = 1 and resultSrc = 2'b10.
- R2: On that instruction, wbData equals the old rd value plus the signed product of the rs1 and rs2 values. Only the low 32 bits of the product and of the sum are kept, and overflow wraps. The value is written into rd at the next rising edge.
- R3: When rd equals rs1 or rs2, every operand is the value held before the edge. Word 32'h0262828B with x5 = 66 and x6 = 10, issued four times back to back, gives 726, 7986, 87846 and 966306.
- R4: rs1Data, rs2Data and rdData combinationally show the registers addressed by instruction bits [19:15], [24:20] and [11:7].
- R5: Register x0 reads as zero on all three ports, and every write to it is discarded.
- R6: A store (opcode 7'b0100011) drives regWrite = 0 and macEnable = 0 and changes no register.
- R7: Opcode 7'b0001011 with any other funct3 or funct7 value is a no-op with regWrite = 0 and macEnable = 0. The same holds for any opcode not listed in R1, R8 or R9. None of these changes a register.
- R8: A load (opcode 7'b0000011) drives regWrite = 1, macEnable = 0 and resultSrc = 2'b01, and writes loadData into rd.
- R9: Register-register (7'b0110011) and register-immediate (7'b0010011) opcodes drive regWrite = 1, macEnable = 0 and resultSrc = 2'b00, and write aluResult into rd.
- R10: A synchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register file |
| instr | input | 32 | Instruction word of the current cycle |
| aluResult | input | 32 | Result of the base ALU |
| loadData | input | 32 | Data returned by a load |
| regWrite | output | 1 | Register write strobe from the decoder |
| macEnable | output | 1 | High for a multiply-accumulate instruction |
| resultSrc | output | 2 | Writeback select: 00 ALU, 01 load data, 10 MAC, 11 falls back to ALU |
| wbData | output | 32 | Value selected for writeback |
| rs1Data | output | 32 | Register read through the rs1 field |
| rs2Data | output | 32 | Register read through the rs2 field |
| rdData | output | 32 | Register read through the rd field (accumulator) |

## Verification
The bench aims at the accumulate chain where rd equals rs1. A design that forwarded the freshly written value would drift off the expected 726, 7986, 87846 and 966306 sequence. It multiplies signed and wrapping operands, where a design that sign-handled wrongly or saturated would give a wrong low word. It also sends MAC and load writes to x0, which a design with a writable x0 would later read back as nonzero. Custom-0 words whose funct3 or funct7 is slightly off, and stores, must leave every register untouched; a decoder that matched on the opcode alone would corrupt rd.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;

  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_STORE   = 7'b0100011;
  localparam logic [6:0] OPC_REG     = 7'b0110011;
  localparam logic [6:0] OPC_IMM     = 7'b0010011;
  localparam logic [2:0] MAC_FUNCT3  = 3'b000;
  localparam logic [6:0] MAC_FUNCT7  = 7'b0000001;

  typedef enum logic [1:0] {
    SRC_ALU = 2'b00,
    SRC_MEM = 2'b01,
    SRC_MAC = 2'b10
  } srcSel_t;

  typedef struct packed {
    logic    regWrite;
    logic    macEnable;
    srcSel_t resultSrc;
  } ctrlStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic [6:0]   opcode,
  input  logic [2:0]   funct3,
  input  logic [6:0]   funct7,
  output ctrlStrobes_t strobes
);
  logic isMacWord;
  assign isMacWord = (funct3 == MAC_FUNCT3) && (funct7 == MAC_FUNCT7);

  always_comb begin
    strobes.regWrite  = 1'b0;
    strobes.macEnable = 1'b0;
    strobes.resultSrc = SRC_ALU;
    unique case (opcode)
      OPC_CUSTOM0: if (isMacWord) begin
        strobes.regWrite  = 1'b1;
        strobes.macEnable = 1'b1;
        strobes.resultSrc = SRC_MAC;
      end
      OPC_LOAD: begin
        strobes.regWrite  = 1'b1;
        strobes.resultSrc = SRC_MEM;
      end
      OPC_REG, OPC_IMM: strobes.regWrite = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_regfile.sv
module mac_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             writeEn,
  input  logic [AW-1:0]    writeAddr,
  input  logic [WIDTH-1:0] writeData,
  input  logic [AW-1:0]    addrA,
  input  logic [AW-1:0]    addrB,
  input  logic [AW-1:0]    addrC,
  output logic [WIDTH-1:0] dataA,
  output logic [WIDTH-1:0] dataB,
  output logic [WIDTH-1:0] dataC
);
  logic [WIDTH-1:0] regs [DEPTH];

  assign regs[0] = '0;

  for (genvar g = 1; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (writeEn && writeAddr == AW'(g))
        regs[g] <= writeData;
    end
  end

  assign dataA = regs[addrA];
  assign dataB = regs[addrB];
  assign dataC = regs[addrC];
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int DEPTH = NREGS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [AW-1:0]    rs1Addr,
  input  logic [AW-1:0]    rs2Addr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] aluResult,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] wbData,
  output logic [WIDTH-1:0] rs1Data,
  output logic [WIDTH-1:0] rs2Data,
  output logic [WIDTH-1:0] rdData
);
  logic signed [WIDTH-1:0] product;
  logic        [WIDTH-1:0] macResult;

  mac_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rf (
    .clk(clk), .rst(rst),
    .writeEn(strobes.regWrite), .writeAddr(rdAddr), .writeData(wbData),
    .addrA(rs1Addr), .addrB(rs2Addr), .addrC(rdAddr),
    .dataA(rs1Data), .dataB(rs2Data), .dataC(rdData)
  );

  // Low word of a signed product, then a wrapping add onto the accumulator.
  assign product   = $signed(rs1Data) * $signed(rs2Data);
  assign macResult = rdData + product;

  always_comb begin
    case (strobes.resultSrc)
      SRC_MEM: wbData = loadData;
      SRC_MAC: wbData = macResult;
      default: wbData = aluResult;
    endcase
  end
endmodule

// File: rtl/mac_wb_slice.sv
module mac_wb_slice
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] aluResult,
  input  logic [31:0] loadData,
  output logic        regWrite,
  output logic        macEnable,
  output logic [1:0]  resultSrc,
  output logic [31:0] wbData,
  output logic [31:0] rs1Data,
  output logic [31:0] rs2Data,
  output logic [31:0] rdData
);
  ctrlStrobes_t strobes;

  mac_ctrl u_ctrl (
    .opcode(instr[6:0]), .funct3(instr[14:12]), .funct7(instr[31:25]),
    .strobes(strobes)
  );

  mac_datapath #(.WIDTH(XLEN), .DEPTH(NREGS)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .rs1Addr(instr[19:15]), .rs2Addr(instr[24:20]), .rdAddr(instr[11:7]),
    .aluResult(aluResult), .loadData(loadData),
    .wbData(wbData), .rs1Data(rs1Data), .rs2Data(rs2Data), .rdData(rdData)
  );

  assign regWrite  = strobes.regWrite;
  assign macEnable = strobes.macEnable;
  assign resultSrc = strobes.resultSrc;
endmodule

// File: rtl/mac_wb_slice_chk.sv
module mac_wb_slice_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic        regWrite,
  input logic        macEnable,
  input logic [1:0]  resultSrc,
  input logic [31:0] wbData,
  input logic [31:0] rs1Data,
  input logic [31:0] rs2Data,
  input logic [31:0] rdData
);
  // R1
  mac_flags_chk: assert property (@(posedge clk) disable iff (rst)
    macEnable |-> (regWrite && resultSrc == 2'b10));

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    ((instr[19:15] == 5'd0 -> rs1Data == 32'd0) &&
     (instr[24:20] == 5'd0 -> rs2Data == 32'd0) &&
     (instr[11:7]  == 5'd0 -> rdData  == 32'd0)));

  // R6
  store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[6:0] == 7'b0100011) |-> (!regWrite && !macEnable));

  // R7
  bad_custom_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[6:0] == 7'b0001011 && (instr[14:12] != 3'b000 || instr[31:25] != 7'b0000001))
      |-> (!regWrite && !macEnable));

  // R2
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(regWrite) && $past(instr[11:7]) != 5'd0 &&
     instr[11:7] == $past(instr[11:7])) |-> (rdData == $past(wbData)));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rs1Data == 32'd0 && rs2Data == 32'd0 && rdData == 32'd0));
endmodule

bind mac_wb_slice mac_wb_slice_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .regWrite(regWrite), .macEnable(macEnable),
  .resultSrc(resultSrc), .wbData(wbData), .rs1Data(rs1Data), .rs2Data(rs2Data),
  .rdData(rdData)
);

// File: tb/mac_wb_slice_test.sv
`timescale 1ns/1ps
module mac_wb_slice_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0000_0023;
  logic [31:0] aluIn = '0;
  logic [31:0] loadIn = '0;
  logic        regWrite, macEnable;
  logic [1:0]  resultSrc;
  logic [31:0] wbData, rs1Data, rs2Data, rdData;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  mac_wb_slice uut (
    .clk(clk), .rst(rst), .instr(instr), .aluResult(aluIn), .loadData(loadIn),
    .regWrite(regWrite), .macEnable(macEnable), .resultSrc(resultSrc),
    .wbData(wbData), .rs1Data(rs1Data), .rs2Data(rs2Data), .rdData(rdData)
  );

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
      input logic [4:0] r1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, r2, r1, f3, rd, op};
  endfunction

  // 0 none, 1 alu, 2 load, 3 mac
  function automatic int kindOf(input logic [31:0] w);
    case (w[6:0])
      7'b0001011: return (w[14:12] == 3'b000 && w[31:25] == 7'b0000001) ? 3 : 0;
      7'b0000011: return 2;
      7'b0110011, 7'b0010011: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic [31:0] alu, input logic [31:0] ld, input string tag);
    int k;
    logic [31:0] exp;
    logic [1:0] expSrc;
    @(negedge clk);
    instr = w; aluIn = alu; loadIn = ld;
    #1;
    k = kindOf(w);
    chk(rs1Data === model[w[19:15]], {tag, " R4 rs1Data"}, rs1Data, model[w[19:15]]);
    chk(rs2Data === model[w[24:20]], {tag, " R4 rs2Data"}, rs2Data, model[w[24:20]]);
    chk(rdData === model[w[11:7]], {tag, " R4 rdData"}, rdData, model[w[11:7]]);
    chk(regWrite === (k != 0), {tag, " regWrite"}, {31'd0, regWrite}, {31'd0, k != 0});
    chk(macEnable === (k == 3), {tag, " macEnable"}, {31'd0, macEnable}, {31'd0, k == 3});
    if (k != 0) begin
      exp = (k == 3) ? model[w[11:7]] + model[w[19:15]] * model[w[24:20]] :
            (k == 2) ? ld : alu;
      expSrc = (k == 3) ? 2'b10 : (k == 2) ? 2'b01 : 2'b00;
      chk(resultSrc === expSrc, {tag, " resultSrc"}, {30'd0, resultSrc}, {30'd0, expSrc});
      chk(wbData === exp, {tag, " wbData"}, wbData, exp);
      if (w[11:7] != 5'd0) model[w[11:7]] = exp;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; instr = 32'h0000_0023;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  task automatic loadReg(input logic [4:0] r, input logic [31:0] v, input string tag);
    step(enc(7'd0, 5'd0, 5'd1, 3'b010, r, 7'b0000011), 32'h1111_1111, v, tag);
  endtask

  task automatic readRegs(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input string tag);
    step(enc(7'd0, b, a, 3'b010, c, 7'b0100011), 32'hAAAA_AAAA, 32'h5555_5555, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] chain [4];
    chain[0] = 32'd726; chain[1] = 32'd7986; chain[2] = 32'd87846; chain[3] = 32'd966306;
    void'($urandom(32'd20240613));
    for (int i = 0; i < 32; i++) model[i] = '0;

    // R10 reset state: every register reads zero
    doReset();
    for (int r = 0; r < 32; r += 3)
      readRegs(5'(r), 5'(r + 1), 5'(r + 2), "R10");

    // R3 accumulate chain with rd == rs1
    loadReg(5'd5, 32'd66, "R8");
    loadReg(5'd6, 32'd10, "R8");
    for (int i = 0; i < 4; i++) begin
      step(32'h0262828B, 32'h0, 32'h0, "R3");
      chk(wbData === chain[i], "R3 chain value", wbData, chain[i]);
    end
    readRegs(5'd5, 5'd6, 5'd5, "R3");

    // R2 wrap: 5 + 0x7fffffff*2 = 3
    loadReg(5'd1, 32'h7FFF_FFFF, "R8");
    loadReg(5'd2, 32'd2, "R8");
    loadReg(5'd3, 32'd5, "R8");
    step(enc(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0001011), 0, 0, "R2");
    chk(wbData === 32'd3, "R2 wrap", wbData, 32'd3);
    // R2 signed: 100 + (-3)*7 = 79
    loadReg(5'd7, 32'hFFFF_FFFD, "R8");
    loadReg(5'd8, 32'd7, "R8");
    loadReg(5'd9, 32'd100, "R8");
    step(enc(7'b0000001, 5'd8, 5'd7, 3'b000, 5'd9, 7'b0001011), 0, 0, "R2");
    chk(wbData === 32'd79, "R2 signed", wbData, 32'd79);
    // R1 rs1 == rs2 == rd: 3 + 3*3 = 12
    step(enc(7'b0000001, 5'd3, 5'd3, 3'b000, 5'd3, 7'b0001011), 0, 0, "R1");
    chk(wbData === 32'd12, "R1 square", wbData, 32'd12);

    // R5 writes to x0 discarded
    loadReg(5'd0, 32'hDEAD_BEEF, "R5");
    step(enc(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd0, 7'b0001011), 0, 0, "R5");
    step(enc(7'd0, 5'd2, 5'd1, 3'b000, 5'd0, 7'b0110011), 32'h1234_5678, 0, "R5");
    readRegs(5'd0, 5'd0, 5'd0, "R5");

    // R7 near-miss custom-0 words and unknown opcodes
    step(enc(7'b0000001, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0001011), 0, 0, "R7");
    step(enc(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0001011), 0, 0, "R7");
    step(enc(7'b1000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0001011), 0, 0, "R7");
    step(enc(7'd0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1101111), 32'hFFFF_FFFF, 0, "R7");
    readRegs(5'd3, 5'd3, 5'd3, "R7");

    // R6 store leaves registers alone
    step(enc(7'd0, 5'd9, 5'd5, 3'b010, 5'd9, 7'b0100011), 32'hABCD_0000, 32'h0000_ABCD, "R6");
    readRegs(5'd9, 5'd5, 5'd9, "R6");

    // R9 ALU writes
    step(enc(7'd0, 5'd2, 5'd1, 3'b000, 5'd10, 7'b0110011), 32'hCAFE_0001, 0, "R9");
    step(enc(7'd0, 5'd0, 5'd1, 3'b000, 5'd11, 7'b0010011), 32'hCAFE_0002, 0, "R9");
    readRegs(5'd10, 5'd11, 5'd10, "R9");

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [4:0] a, b, d;
      logic [31:0] w;
      string tag;
      sel = $urandom_range(0, 5);
      a = 5'($urandom_range(0, 31));
      b = 5'($urandom_range(0, 31));
      d = ($urandom_range(0, 3) == 0) ? a : 5'($urandom_range(0, 31));
      case (sel)
        0, 1: begin w = enc(7'b0000001, b, a, 3'b000, d, 7'b0001011); tag = "R2"; end
        2: begin w = enc(7'd0, b, a, 3'b010, d, 7'b0000011); tag = "R8"; end
        3: begin w = enc(7'd0, b, a, 3'b000, d, ($urandom_range(0, 1) != 0) ? 7'b0110011 : 7'b0010011); tag = "R9"; end
        4: begin w = enc(7'd0, b, a, 3'b010, d, 7'b0100011); tag = "R6"; end
        default: begin
          w = enc(7'($urandom_range(0, 127)), b, a, 3'($urandom_range(1, 7)), d, 7'b0001011);
          tag = "R7";
        end
      endcase
      step(w, $urandom(), $urandom(), tag);
    end

    // R10 reset in mid-run
    doReset();
    readRegs(5'd5, 5'd3, 5'd9, "R10");
    readRegs(5'd10, 5'd11, 5'd31, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule